// File: doc/BRIEF.md
# UART Receive Status and DMA Request Gating

This block is the status side of a UART receiver. Each cycle it may be handed one finished character, with its parity, framing and noise error bits. It keeps the holding register that software or DMA reads. It also keeps the "data waiting" flag, the overrun flag, the three sticky error flags and a wakeup flag. From this state it drives the DMA receive request and the error interrupt.

Three configuration fields pass through a lock and take a new value only while the UART is disabled. They are overrun disable, drop-versus-mask error handling and the wakeup event select. The DMA enable and the interrupt enable are plain static inputs.

The error handling mode changes what happens to a corrupted character:
- In drop mode, the character is discarded and only its error flags record it.
- In mask mode, the character is kept, but the DMA request stays masked until software clears every error flag.

Top module: `uart_rx_status`

## Requirements
- R1: A character that is accepted and does not cause an overrun is written into the holding register `rx_data_o` on the clock where `rx_valid_i` is high.
- R2: `rxne_o` goes to 1 when an accepted character is stored, and clears on the clock where `rd_i` or `dma_ack_i` is high. A character that arrives in the same cycle as a read or acknowledge is stored, and `rxne_o` stays 1.
- R3: With overrun disable at 0, a character accepted while `rxne_o` is 1 and not being read in that cycle sets `ore_o`. The held data is kept unchanged.
- R4: With overrun disable at 1, `ore_o` is never set. A new accepted character overwrites the held data and `rxne_o` stays 1.
- R5: In drop mode (mode bit 0), a character with any error bit sets its error flags. It does not load data, does not set `rxne_o` and cannot cause an overrun.
- R6: In mask mode (mode bit 1), a character with errors sets its error flags and is stored like a good character.
- R7: `dma_req_o` is `dma_rx_en_i AND rxne_o AND NOT (mask mode AND (pe_o OR fe_o OR ne_o))`.
- R8: Each of `pe_o`, `fe_o`, `ne_o` and `ore_o` stays 1 until its clear strobe is high. A set and a clear in the same cycle leave the flag at 1.
- R9: `err_irq_o` is `err_irq_en_i AND (fe_o OR ne_o OR ore_o)`. A parity error alone does not raise it.
- R10: The 2-bit wakeup select chooses the event that sets `wake_o`:
  - 0: a valid character equal to `match_addr_i`.
  - 1: reserved, never sets the flag.
  - 2: `rx_start_i`.
  - 3: a 0-to-1 transition of `rxne_o`.
  
  `wake_o` stays 1 until `clr_wake_i`, and a set wins over a clear in the same cycle.
- R11: Overrun disable, the error mode bit and the wakeup select load from their inputs only on a clock where `cfg_wr_i` is 1 and `uart_en_i` is 0. All other writes are ignored. Reset value of all three is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uart_en_i | input | 1 | UART enabled; locks configuration |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_ovr_dis_i | input | 1 | Overrun disable value to write |
| cfg_err_mask_i | input | 1 | Error mode to write (0 drop, 1 mask) |
| cfg_wake_sel_i | input | 2 | Wakeup select value to write |
| dma_rx_en_i | input | 1 | DMA receive enable |
| err_irq_en_i | input | 1 | Error interrupt enable |
| rx_valid_i | input | 1 | Character received strobe |
| rx_data_i | input | DATA_W | Received character |
| rx_perr_i | input | 1 | Parity error on character |
| rx_ferr_i | input | 1 | Framing error on character |
| rx_nerr_i | input | 1 | Noise detected on character |
| rx_start_i | input | 1 | Start bit detected |
| match_addr_i | input | DATA_W | Address for wakeup match |
| rd_i | input | 1 | Software read of holding register |
| dma_ack_i | input | 1 | DMA acknowledge |
| clr_pe_i | input | 1 | Clear parity flag |
| clr_fe_i | input | 1 | Clear framing flag |
| clr_ne_i | input | 1 | Clear noise flag |
| clr_ore_i | input | 1 | Clear overrun flag |
| clr_wake_i | input | 1 | Clear wakeup flag |
| rx_data_o | output | DATA_W | Holding register |
| rxne_o | output | 1 | Data waiting |
| pe_o | output | 1 | Parity error flag |
| fe_o | output | 1 | Framing error flag |
| ne_o | output | 1 | Noise flag |
| ore_o | output | 1 | Overrun flag |
| dma_req_o | output | 1 | DMA receive request |
| err_irq_o | output | 1 | Error interrupt |
| wake_o | output | 1 | Wakeup flag |

## Verification
The assertions assume at most one character per cycle and assume the strobes are single-cycle events. They do not assume that software waits for an acknowledge, so reads, clears and arrivals may coincide in any combination. The bench keeps to this by driving each strobe for exactly one clock.

The stimulus has two parts:
- Directed sequences toggle the enable and configuration between character bursts.
- A random phase then drives free combinations of arrivals, clears and reads. In that phase, configuration writes are attempted in both the enabled and the disabled state.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;
    localparam int FLAG_PE  = 0;
    localparam int FLAG_FE  = 1;
    localparam int FLAG_NE  = 2;
    localparam int FLAG_ORE = 3;
    localparam int NUM_FLAGS = 4;

    typedef enum logic [1:0] {
        WAKE_ADDR  = 2'd0,
        WAKE_RSVD  = 2'd1,
        WAKE_START = 2'd2,
        WAKE_RXNE  = 2'd3
    } wake_sel_e;

    typedef struct packed {
        logic      ovr_dis;
        logic      err_mask;
        wake_sel_e wake_sel;
    } rx_cfg_t;
endpackage

// File: rtl/urs_cfg_lock.sv
module urs_cfg_lock
    import uart_rx_status_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    uart_en_i,
    input  logic    wr_i,
    input  rx_cfg_t cfg_i,
    output rx_cfg_t cfg_o
);
    rx_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i && !uart_en_i) cfg_d = cfg_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R11: configuration frozen while the UART is enabled
    a_r11_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uart_en_i |=> $stable(cfg_q));
endmodule

// File: rtl/urs_sticky_flag.sv
module urs_sticky_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R8: flag holds without a clear; a set always lands
    a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_q && !clr_i) |=> flag_q);
    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> flag_q);
endmodule

// File: rtl/urs_wake_detect.sv
module urs_wake_detect
    import uart_rx_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  wake_sel_e          sel_i,
    input  logic               rx_valid_i,
    input  logic [DATA_W-1:0]  rx_data_i,
    input  logic [DATA_W-1:0]  match_addr_i,
    input  logic               rx_start_i,
    input  logic               rxne_now_i,
    input  logic               rxne_next_i,
    output logic               event_o
);
    always_comb begin
        unique case (sel_i)
            WAKE_ADDR:  event_o = rx_valid_i && (rx_data_i == match_addr_i);
            WAKE_START: event_o = rx_start_i;
            WAKE_RXNE:  event_o = rxne_next_i && !rxne_now_i;
            default:    event_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              uart_en_i,
    input  logic              cfg_wr_i,
    input  logic              cfg_ovr_dis_i,
    input  logic              cfg_err_mask_i,
    input  logic [1:0]        cfg_wake_sel_i,
    input  logic              dma_rx_en_i,
    input  logic              err_irq_en_i,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              rx_perr_i,
    input  logic              rx_ferr_i,
    input  logic              rx_nerr_i,
    input  logic              rx_start_i,
    input  logic [DATA_W-1:0] match_addr_i,
    input  logic              rd_i,
    input  logic              dma_ack_i,
    input  logic              clr_pe_i,
    input  logic              clr_fe_i,
    input  logic              clr_ne_i,
    input  logic              clr_ore_i,
    input  logic              clr_wake_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rxne_o,
    output logic              pe_o,
    output logic              fe_o,
    output logic              ne_o,
    output logic              ore_o,
    output logic              dma_req_o,
    output logic              err_irq_o,
    output logic              wake_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              rxne;
    } hold_t;

    rx_cfg_t cfg_in, cfg;
    hold_t   st_d, st_q;
    logic    err_in, pop, drop, accept, overrun, load, wake_ev;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

    assign cfg_in.ovr_dis  = cfg_ovr_dis_i;
    assign cfg_in.err_mask = cfg_err_mask_i;
    assign cfg_in.wake_sel = wake_sel_e'(cfg_wake_sel_i);

    urs_cfg_lock i_cfg (
        .clk_i(clk_i), .rst_ni(rst_ni), .uart_en_i(uart_en_i),
        .wr_i(cfg_wr_i), .cfg_i(cfg_in), .cfg_o(cfg)
    );

    always_comb begin
        err_in  = rx_perr_i || rx_ferr_i || rx_nerr_i;
        pop     = rd_i || dma_ack_i;
        drop    = rx_valid_i && err_in && !cfg.err_mask;
        accept  = rx_valid_i && !drop;
        overrun = accept && st_q.rxne && !pop && !cfg.ovr_dis;
        load    = accept && !overrun;

        st_d = st_q;
        if (pop)  st_d.rxne = 1'b0;
        if (load) begin
            st_d.data = rx_data_i;
            st_d.rxne = 1'b1;
        end

        flag_set[FLAG_PE]  = rx_valid_i && rx_perr_i;
        flag_set[FLAG_FE]  = rx_valid_i && rx_ferr_i;
        flag_set[FLAG_NE]  = rx_valid_i && rx_nerr_i;
        flag_set[FLAG_ORE] = overrun;
        flag_clr[FLAG_PE]  = clr_pe_i;
        flag_clr[FLAG_FE]  = clr_fe_i;
        flag_clr[FLAG_NE]  = clr_ne_i;
        flag_clr[FLAG_ORE] = clr_ore_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        urs_sticky_flag i_flag (
            .clk_i(clk_i), .rst_ni(rst_ni),
            .set_i(flag_set[g]), .clr_i(flag_clr[g]), .flag_o(flag_q[g])
        );
    end

    urs_wake_detect #(.DATA_W(DATA_W)) i_wake_det (
        .sel_i(cfg.wake_sel), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
        .match_addr_i(match_addr_i), .rx_start_i(rx_start_i),
        .rxne_now_i(st_q.rxne), .rxne_next_i(st_d.rxne), .event_o(wake_ev)
    );

    urs_sticky_flag i_wake_flag (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .set_i(wake_ev), .clr_i(clr_wake_i), .flag_o(wake_o)
    );

    assign rx_data_o = st_q.data;
    assign rxne_o    = st_q.rxne;
    assign pe_o      = flag_q[FLAG_PE];
    assign fe_o      = flag_q[FLAG_FE];
    assign ne_o      = flag_q[FLAG_NE];
    assign ore_o     = flag_q[FLAG_ORE];
    assign dma_req_o = dma_rx_en_i && st_q.rxne &&
                       !(cfg.err_mask && (flag_q[FLAG_PE] || flag_q[FLAG_FE] || flag_q[FLAG_NE]));
    assign err_irq_o = err_irq_en_i && (flag_q[FLAG_FE] || flag_q[FLAG_NE] || flag_q[FLAG_ORE]);

    // R2: a read or acknowledge with no arrival empties the register
    a_r2_pop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rd_i || dma_ack_i) && !rx_valid_i) |=> !rxne_o);
    // R3: overrun only from an arrival onto unread data
    a_r3_ore_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ore_o) |-> $past(rx_valid_i && rxne_o));
    // R4: overrun never raised while detection is disabled
    a_r4_ore_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ore_o) |-> !$past(cfg.ovr_dis));
    // R5: a dropped character leaves the holding register untouched
    a_r5_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_i && (rx_perr_i || rx_ferr_i || rx_nerr_i) && !cfg.err_mask)
        |=> $stable(rx_data_o));
    // R10: reserved select never wakes
    a_r10_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wake_o) |-> ($past(cfg.wake_sel) != WAKE_RSVD));
endmodule

// File: tb/test_uart_rx_status.sv
module test_uart_rx_status;
    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;

    logic uart_en = 0, cfg_wr = 0, cfg_ovr = 0, cfg_msk = 0;
    logic [1:0] cfg_sel = 0;
    logic dma_en = 0, irq_en = 0, rxv = 0, perr = 0, ferr = 0, nerr = 0, start = 0;
    logic [7:0] rxd = 0, addr = 8'h3C;
    logic rd = 0, ack = 0, cpe = 0, cfe = 0, cne = 0, core = 0, cwk = 0;
    logic [7:0] d_o;
    logic rxne_o, pe_o, fe_o, ne_o, ore_o, dreq_o, irq_o, wake_o;

    uart_rx_status i_uart_rx_status (
        .clk_i(clk), .rst_ni(rst_n), .uart_en_i(uart_en), .cfg_wr_i(cfg_wr),
        .cfg_ovr_dis_i(cfg_ovr), .cfg_err_mask_i(cfg_msk), .cfg_wake_sel_i(cfg_sel),
        .dma_rx_en_i(dma_en), .err_irq_en_i(irq_en), .rx_valid_i(rxv), .rx_data_i(rxd),
        .rx_perr_i(perr), .rx_ferr_i(ferr), .rx_nerr_i(nerr), .rx_start_i(start),
        .match_addr_i(addr), .rd_i(rd), .dma_ack_i(ack), .clr_pe_i(cpe), .clr_fe_i(cfe),
        .clr_ne_i(cne), .clr_ore_i(core), .clr_wake_i(cwk), .rx_data_o(d_o),
        .rxne_o(rxne_o), .pe_o(pe_o), .fe_o(fe_o), .ne_o(ne_o), .ore_o(ore_o),
        .dma_req_o(dreq_o), .err_irq_o(irq_o), .wake_o(wake_o)
    );

    // behavioural reference
    int m_data; bit m_rxne, m_pe, m_fe, m_ne, m_ore, m_wake, m_ovr, m_msk;
    int m_sel;
    int nchk = 0, nfail = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_data = 0; m_rxne = 0; m_pe = 0; m_fe = 0; m_ne = 0; m_ore = 0;
            m_wake = 0; m_ovr = 0; m_msk = 0; m_sel = 0;
        end else begin
            bit was_full, keep, bad, wk, ovr_now;
            was_full = m_rxne;
            bad = perr | ferr | nerr;
            ovr_now = 0;
            wk = 0;
            if (cpe) m_pe = 0;
            if (cfe) m_fe = 0;
            if (cne) m_ne = 0;
            if (core) m_ore = 0;
            if (cwk) m_wake = 0;
            if (rd || ack) m_rxne = 0;
            if (rxv) begin
                if (perr) m_pe = 1;
                if (ferr) m_fe = 1;
                if (nerr) m_ne = 1;
                keep = !(bad && !m_msk);
                if (keep) begin
                    if (m_rxne && !m_ovr) ovr_now = 1;
                    else begin m_data = rxd; m_rxne = 1; end
                end
                if (m_sel == 0 && rxd == addr) wk = 1;
            end
            if (ovr_now) m_ore = 1;
            if (m_sel == 2 && start) wk = 1;
            if (m_sel == 3 && m_rxne && !was_full) wk = 1;
            if (wk) m_wake = 1;
            if (cfg_wr && !uart_en) begin m_ovr = cfg_ovr; m_msk = cfg_msk; m_sel = cfg_sel; end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        chk("R1 holding data", d_o, m_data);
        chk("R2 rxne", rxne_o, m_rxne);
        chk("R3 R4 overrun flag", ore_o, m_ore);
        chk("R5 R6 R8 parity flag", pe_o, m_pe);
        chk("R5 R6 R8 framing flag", fe_o, m_fe);
        chk("R5 R6 R8 noise flag", ne_o, m_ne);
        chk("R7 R11 dma request", dreq_o,
            dma_en && m_rxne && !(m_msk && (m_pe || m_fe || m_ne)));
        chk("R9 error irq", irq_o, irq_en && (m_fe || m_ne || m_ore));
        chk("R10 wake flag", wake_o, m_wake);
    end

    task automatic tick();
        @(posedge clk); #5;
        cfg_wr = 0; rxv = 0; perr = 0; ferr = 0; nerr = 0; start = 0;
        rd = 0; ack = 0; cpe = 0; cfe = 0; cne = 0; core = 0; cwk = 0;
    endtask

    task automatic recv(input logic [7:0] d, input logic p, input logic f, input logic n);
        rxv = 1; rxd = d; perr = p; ferr = f; nerr = n; tick();
    endtask

    task automatic setcfg(input logic o, input logic m, input logic [1:0] s);
        cfg_wr = 1; cfg_ovr = o; cfg_msk = m; cfg_sel = s; tick();
    endtask

    task automatic clr_all();
        cpe = 1; cfe = 1; cne = 1; core = 1; cwk = 1; rd = 1; tick();
    endtask

    initial begin
        #150000000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        dma_en = 1; irq_en = 1; uart_en = 1;
        // R1 R2 good character then read
        recv(8'hA5, 0, 0, 0); tick(); rd = 1; tick(); tick();
        // R3 overrun, data kept
        recv(8'h11, 0, 0, 0); recv(8'h22, 0, 0, 0); tick();
        // R2 arrival with read same cycle
        rd = 1; recv(8'h33, 0, 0, 0); tick();
        clr_all();
        // R11 config locked while enabled
        setcfg(1, 1, 2); recv(8'h44, 0, 0, 0); recv(8'h55, 0, 0, 0); clr_all();
        // R4 overrun disabled
        uart_en = 0; setcfg(1, 0, 0); uart_en = 1;
        recv(8'h66, 0, 0, 0); recv(8'h77, 0, 0, 0); tick(); clr_all();
        // R5 drop mode, R9 parity alone
        recv(8'h88, 1, 0, 0); tick(); recv(8'h99, 0, 1, 1); tick();
        recv(8'hAA, 0, 0, 0); tick(); clr_all();
        // R6 mask mode
        uart_en = 0; setcfg(0, 1, 3); uart_en = 1;
        recv(8'hBB, 0, 1, 0); tick(); tick();
        cfe = 1; tick(); ack = 1; tick();
        // R8 set wins over clear
        cpe = 1; recv(8'hCC, 1, 0, 0); tick(); clr_all();
        // R10 wake selects
        uart_en = 0; setcfg(0, 0, 0); uart_en = 1;
        recv(8'h3C, 0, 0, 0); cwk = 1; recv(8'h3C, 0, 0, 0); tick(); clr_all();
        uart_en = 0; setcfg(0, 0, 1); uart_en = 1; start = 1; recv(8'h3C, 0, 0, 0); clr_all();
        uart_en = 0; setcfg(0, 0, 2); uart_en = 1; start = 1; tick(); tick(); clr_all();
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[31:28] == 0) uart_en = ~uart_en;
            if (r[27:25] == 0) begin
                cfg_wr = 1; cfg_ovr = r[0]; cfg_msk = r[1]; cfg_sel = r[3:2];
            end
            dma_en = r[24] | r[23]; irq_en = r[22] | r[21];
            rxv = r[20] | r[19]; rxd = (r[18]) ? addr : r[15:8];
            perr = r[17] & r[16]; ferr = r[7] & r[6] & r[5]; nerr = r[4] & r[30] & r[29];
            start = r[5] & r[4];
            rd = r[2] & r[1]; ack = r[3] & r[0] & r[6];
            cpe = r[9] & r[10]; cfe = r[11] & r[12]; cne = r[13] & r[14];
            core = r[15] & r[16]; cwk = r[26] & r[7];
            tick();
        end
        tick();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule